// File: doc/BRIEF.md
# Selectable-Period Supervisor Watchdog

This block watches a host for signs of life. The host must kick it regularly, for example on every chip-select edge. If the host stays silent for longer than the selected period, the block pulls the system reset low. A two-bit period code chooses one of three fixed periods or switches the watchdog off. Time is counted in millisecond ticks supplied by an external single-cycle enable, so the same logic works at any clock rate.

Once the watchdog fires, the reset is held for a fixed minimum number of ticks and then released. A power-on reset also holds the system reset for that same minimum time. When the reset came from a timeout, the block emits a one-cycle cause pulse. This lets the surrounding logic record the cause and tell a watchdog reset apart from a power failure.

The reset pin is modelled as the enable of an open-drain driver. A high enable means the pin is pulled low.

Top module: `wdog_supervisor`

## Requirements
- R1: With `sel` = 2'b00, 2'b01 or 2'b10, the drive enable rises on the LONG_MS-th, MID_MS-th or SHORT_MS-th tick respectively after the count last restarted, with no kick in between, and not before.
- R2: With `sel` = 2'b11 the count is frozen, and no timeout drive or cause pulse ever occurs, however many ticks arrive.
- R3: `rst_n_oe` = 1 means the open-drain reset pin is pulled low (reset active); `rst_n_oe` = 0 means the pin is released.
- R4: Once a timeout drive starts, `rst_n_oe` stays 1 for exactly HOLD_MS ticks and falls on the HOLD_MS-th tick.
- R5: `wd_cause` is high for exactly one clock cycle, in the first cycle of a timeout-driven reset, and at no other time.
- R6: A kick restarts the count from zero, so a full period of ticks after the kick is needed for a timeout.
- R7: Kicks while the reset is driven have no effect on the hold length.
- R8: A change of `sel` restarts the count from zero under the new period.
- R9: While `rst` is high and for HOLD_MS ticks after it falls, `rst_n_oe` is 1, and `wd_cause` stays 0 throughout.
- R10: Clock cycles without `tick_ms` do not advance either the watchdog count or the hold count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_ms | input | 1 | One-cycle millisecond time base enable |
| kick | input | 1 | Host activity strobe; restarts the count |
| sel | input | 2 | Period code: 00 long, 01 mid, 10 short, 11 off |
| rst_n_oe | output | 1 | Open-drain enable of the active-low reset pin |
| wd_cause | output | 1 | One-cycle pulse marking a watchdog-caused reset |

## Verification
The bench sweeps a kick over every tick position inside each of the three periods. This catches a counter that fires one tick early or late, and a kick that fails to reset the count to zero. The hold is measured tick by tick while kicks arrive, which exposes a stretcher that ends early or lets a kick restart it. A period code change partway through a long count catches logic that keeps the old count against the new limit. Long tick runs with the off code, and idle cycles between ticks, catch a watchdog that still fires when disabled or that counts clock cycles instead of ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int LIM_W = 16;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

    typedef struct packed {
        logic             on;
        logic [LIM_W-1:0] limit;
    } period_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } sup_state_t;

    function automatic period_t pick_period(input logic [1:0] code,
                                            input int long_ms,
                                            input int mid_ms,
                                            input int short_ms);
        period_t p;
        p.on = 1'b1;
        unique case (code)
            SEL_LONG:  p.limit = LIM_W'(long_ms);
            SEL_MID:   p.limit = LIM_W'(mid_ms);
            SEL_SHORT: p.limit = LIM_W'(short_ms);
            default: begin
                p.on    = 1'b0;
                p.limit = LIM_W'(long_ms);
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/wdog_period_sel.sv
module wdog_period_sel
    import wdog_pkg::*;
#(
    parameter int LONG_MS  = 1400,
    parameter int MID_MS   = 600,
    parameter int SHORT_MS = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output period_t    cfg,
    output logic       changed
);
    logic [1:0] sel_q;

    always_ff @(posedge clk) begin
        sel_q <= sel;
    end

    assign cfg     = pick_period(sel, LONG_MS, MID_MS, SHORT_MS);
    assign changed = !rst && (sel != sel_q);

    p_change_seen_r8: assert property (@(posedge clk) disable iff (rst)
        (sel != $past(sel)) |-> changed);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    clear,
    input  period_t cfg,
    output logic    expire
);
    logic [LIM_W-1:0] cnt;

    assign expire = !clear && cfg.on && tick && (cnt == cfg.limit - LIM_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cfg.on && tick) begin
            cnt <= expire ? '0 : cnt + LIM_W'(1);
        end
    end

    p_cnt_below_limit_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg.on && !clear) |-> (cnt < cfg.limit));
    p_off_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg.on && !clear) |=> $stable(cnt));
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));
    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch
    import wdog_pkg::*;
#(
    parameter int HOLD_MS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fire,
    output logic holding
);
    localparam int HW = $clog2(HOLD_MS + 1);

    sup_state_t    state;
    logic [HW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
            hcnt  <= '0;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    if (tick) begin
                        if (hcnt == HW'(HOLD_MS - 1)) begin
                            state <= ST_RUN;
                            hcnt  <= '0;
                        end else begin
                            hcnt <= hcnt + HW'(1);
                        end
                    end
                end
                default: begin
                    if (fire) begin
                        state <= ST_HOLD;
                        hcnt  <= '0;
                    end
                end
            endcase
        end
    end

    assign holding = (state == ST_HOLD);

    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (holding && !tick) |=> holding);
    p_hold_bound_r4: assert property (@(posedge clk) disable iff (rst)
        holding |-> (hcnt < HW'(HOLD_MS)));
    p_fire_enters_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!holding && fire) |=> (holding && hcnt == '0));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int LONG_MS  = 1400,
    parameter int MID_MS   = 600,
    parameter int SHORT_MS = 200,
    parameter int HOLD_MS  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_ms,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       rst_n_oe,
    output logic       wd_cause
);
    period_t cfg;
    logic    changed;
    logic    holding;
    logic    expire;
    logic    clear;
    logic    cause_q;

    wdog_period_sel #(
        .LONG_MS (LONG_MS),
        .MID_MS  (MID_MS),
        .SHORT_MS(SHORT_MS)
    ) u_sel (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .cfg    (cfg),
        .changed(changed)
    );

    assign clear = kick || changed || holding;

    wdog_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_ms),
        .clear (clear),
        .cfg   (cfg),
        .expire(expire)
    );

    wdog_stretch #(
        .HOLD_MS(HOLD_MS)
    ) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_ms),
        .fire   (expire),
        .holding(holding)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= 1'b0;
        end else begin
            cause_q <= expire;
        end
    end

    assign rst_n_oe = holding;
    assign wd_cause = cause_q;

    p_cause_in_reset_r5: assert property (@(posedge clk) disable iff (rst)
        wd_cause |-> rst_n_oe);
    p_cause_single_r5: assert property (@(posedge clk) disable iff (rst)
        wd_cause |=> !wd_cause);
    p_cause_starts_drive_r5: assert property (@(posedge clk) disable iff (rst)
        wd_cause |-> !$past(rst_n_oe));
    p_por_no_cause_r9: assert property (@(posedge clk)
        rst |=> (!wd_cause && rst_n_oe));
endmodule

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb;
    localparam int L = 14;
    localparam int M = 6;
    localparam int S = 3;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_ms = 1'b0;
    logic       kick = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       rst_n_oe;
    logic       wd_cause;

    int vectors = 0;
    int fails = 0;
    logic seen_cause;

    always #2 clk = ~clk;

    wdog_supervisor #(
        .LONG_MS (L),
        .MID_MS  (M),
        .SHORT_MS(S),
        .HOLD_MS (H)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .tick_ms (tick_ms),
        .kick    (kick),
        .sel     (sel),
        .rst_n_oe(rst_n_oe),
        .wd_cause(wd_cause)
    );

    function automatic int lim_of(input logic [1:0] c);
        case (c)
            2'b00:   return L;
            2'b01:   return M;
            default: return S;
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic k);
        tick_ms = t;
        kick    = k;
        @(negedge clk);
        tick_ms = 1'b0;
        kick    = 1'b0;
    endtask

    // one tick, cause sampled right after it, then an idle cycle (R10)
    task automatic tick1(input logic k);
        step(1'b1, k);
        seen_cause = wd_cause;
        step(1'b0, 1'b0);
    endtask

    task automatic release_hold(input logic with_kicks, input string tag);
        for (int i = 1; i <= H; i++) begin
            tick1(with_kicks);
            chk(rst_n_oe, (i < H) ? 1'b1 : 1'b0, tag);
            chk(seen_cause, 1'b0, "R5 no cause during hold");
        end
    endtask

    task automatic expect_timeout(input int n, input string tag);
        for (int i = 1; i <= n; i++) begin
            tick1(1'b0);
            chk(rst_n_oe, (i < n) ? 1'b0 : 1'b1, tag);
            chk(seen_cause, (i < n) ? 1'b0 : 1'b1, "R5 cause pulse");
        end
        chk(wd_cause, 1'b0, "R5 pulse one cycle");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk(rst_n_oe, 1'b1, "R9 drive during rst");
        chk(wd_cause, 1'b0, "R9 no cause in rst");
        rst = 1'b0;
        step(1'b0, 1'b0);
        chk(rst_n_oe, 1'b1, "R3 pulled low after rst");
        release_hold(1'b0, "R9 power-on hold");

        // R1 R4 R5 R7: each period, then hold with kicks
        for (int s = 0; s < 3; s++) begin
            sel = 2'(s);
            step(1'b0, 1'b0);
            expect_timeout(lim_of(2'(s)), "R1 period");
            release_hold(1'b1, "R4 R7 hold with kicks");
        end

        // R6: kick at every position in each period
        for (int s = 0; s < 3; s++) begin
            sel = 2'(s);
            step(1'b0, 1'b0);
            for (int p = 1; p < lim_of(2'(s)); p++) begin
                for (int i = 0; i < p; i++) begin
                    tick1(1'b0);
                    chk(rst_n_oe, 1'b0, "R6 before kick");
                end
                step(1'b0, 1'b1);
                expect_timeout(lim_of(2'(s)), "R6 after kick");
                release_hold(1'b0, "R4 hold");
            end
        end

        // R8: change of period part way through
        sel = 2'b00;
        step(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) tick1(1'b0);
        chk(rst_n_oe, 1'b0, "R8 before change");
        sel = 2'b01;
        step(1'b0, 1'b0);
        expect_timeout(M, "R8 restart on new period");
        release_hold(1'b0, "R4 hold");

        // R2: disabled
        sel = 2'b11;
        step(1'b0, 1'b0);
        for (int i = 0; i < 3 * L; i++) begin
            tick1(1'b0);
            chk(rst_n_oe, 1'b0, "R2 off no drive");
            chk(seen_cause, 1'b0, "R2 off no cause");
        end
        sel = 2'b10;
        step(1'b0, 1'b0);
        expect_timeout(S, "R2 R8 re-enable short");
        release_hold(1'b0, "R4 hold");

        // R10: idle cycles without ticks
        repeat (40) begin
            step(1'b0, 1'b0);
            chk(rst_n_oe, 1'b0, "R10 no tick no advance");
        end
        expect_timeout(S, "R10 count unchanged by idle");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule